// File: doc/BRIEF.md
# Jump Condition and Next-PC Resolver

This block sits beside a processor's execute stage and settles every control transfer in one step. Each cycle it takes a condition code, a jump kind, the four status flags (carry, zero, sign, overflow), the sequential program counter, a label target, a register target and the current link register. From these it decides whether the jump is taken and which address comes next. It also reports whether the link register must be written, and with what value.

The condition code selects one of fourteen flag tests, an always-true test or a never-true test. The jump kind selects the target: the label, a register, or the link register (return). The kind also says whether a return address is saved. For unsigned tests, carry is treated as a borrow. The saved return address is the supplied PC itself, with no offset added. All outputs are registered. Each result appears one clock after its inputs, and a synchronous reset clears the outputs to the not-taken state.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs are cleared to zero at that edge, whatever the other inputs are.
- R2: Each output reflects the inputs sampled at the previous rising edge: one cycle of latency, and no earlier change.
- R3: Condition codes 1/2 test V set/clear, 3/4 test S set/clear, and 5/6 test Z set/clear.
- R4: Code 7 is true when C=1 (unsigned lower) and code 8 is true when C=0 (unsigned higher or same), with carry read as a borrow.
- R5: Code 9 is true when Z|(S^V) is 0, and code 10 is true when it is 1. Code 11 is true when S^V is 1, and code 12 is true when S^V is 0.
- R6: Code 13 is true when C|Z is 0, and code 14 is true when C|Z is 1.
- R7: Code 0 is always true and code 15 is never true.
- R8: When a jump is taken, the next PC comes from the jump kind. Kinds 0 and 1 take the label target, kinds 2 and 3 take the register target, and kind 4 (return) takes the link register input.
- R9: When a jump of kind 1 or 3 is taken, `link_we_o` is 1 and `link_val_o` equals the supplied PC. For every other result, `link_we_o` is 0 and `link_val_o` is 0.
- R10: When the selected condition is false, `taken_o` is 0, the next PC equals the supplied PC, and the link register is not written, even for a linking kind.
- R11: Jump kinds 5, 6 and 7 are never taken, whatever the condition code.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel_i | input | 4 | Condition code (0..15) |
| kind_i | input | 3 | Jump kind (0..7) |
| flag_c_i | input | 1 | Carry/borrow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_v_i | input | 1 | Overflow flag |
| pc_i | input | W | Sequential PC, also the saved return address |
| label_i | input | W | Label target address |
| reg_tgt_i | input | W | Register target address |
| link_i | input | W | Current link register |
| taken_o | output | 1 | Jump taken |
| next_pc_o | output | W | Next program counter |
| link_we_o | output | 1 | Link register write enable |
| link_val_o | output | W | Value to write into the link register |

## Verification
The condition test and the link save act in the same cycle when a linking kind (1 or 3) is paired with a conditional code. A false condition must then suppress both the redirect and the link write. The bench provokes this by sweeping all sixteen flag patterns under every flag test with linking kinds. For each pattern it checks that `link_we_o` rises exactly when the bench's own evaluation of the condition is true, and that `next_pc_o` falls back to the supplied PC otherwise.

// File: rtl/branch_pkg.sv
package branch_pkg;

    typedef enum logic [3:0] {
        COND_ALWAYS  = 4'd0,
        COND_VSET    = 4'd1,
        COND_VCLR    = 4'd2,
        COND_NEG     = 4'd3,
        COND_POS     = 4'd4,
        COND_EQ      = 4'd5,
        COND_NE      = 4'd6,
        COND_ULO     = 4'd7,
        COND_UHS     = 4'd8,
        COND_SGT     = 4'd9,
        COND_SLE     = 4'd10,
        COND_SLT     = 4'd11,
        COND_SGE     = 4'd12,
        COND_UHI     = 4'd13,
        COND_ULS     = 4'd14,
        COND_NEVER   = 4'd15
    } cond_sel_e;

    typedef enum logic [2:0] {
        KIND_LABEL      = 3'd0,
        KIND_LABEL_LINK = 3'd1,
        KIND_REG        = 3'd2,
        KIND_REG_LINK   = 3'd3,
        KIND_RETURN     = 3'd4,
        KIND_RSV5       = 3'd5,
        KIND_RSV6       = 3'd6,
        KIND_RSV7       = 3'd7
    } jump_kind_e;

    localparam int unsigned NUM_COND = 16;

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_pkg::*;
(
    input  cond_sel_e sel_i,
    input  logic      c_i,
    input  logic      z_i,
    input  logic      s_i,
    input  logic      v_i,
    output logic      hit_o
);
    logic [NUM_COND-1:0] tests;
    logic                lt_signed;
    logic                le_signed;
    logic                le_unsigned;

    assign lt_signed   = s_i ^ v_i;
    assign le_signed   = z_i | lt_signed;
    assign le_unsigned = c_i | z_i;

    // Each pair of codes is a test and its complement; build the table once.
    always_comb begin
        tests                   = '0;
        tests[COND_ALWAYS]      = 1'b1;
        tests[COND_VSET]        = v_i;
        tests[COND_VCLR]        = ~v_i;
        tests[COND_NEG]         = s_i;
        tests[COND_POS]         = ~s_i;
        tests[COND_EQ]          = z_i;
        tests[COND_NE]          = ~z_i;
        tests[COND_ULO]         = c_i;
        tests[COND_UHS]         = ~c_i;
        tests[COND_SGT]         = ~le_signed;
        tests[COND_SLE]         = le_signed;
        tests[COND_SLT]         = lt_signed;
        tests[COND_SGE]         = ~lt_signed;
        tests[COND_UHI]         = ~le_unsigned;
        tests[COND_ULS]         = le_unsigned;
        tests[COND_NEVER]       = 1'b0;
    end

    assign hit_o = tests[sel_i];

endmodule

// File: rtl/branch_target_sel.sv
module branch_target_sel
    import branch_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  jump_kind_e     kind_i,
    input  logic [W-1:0]   label_i,
    input  logic [W-1:0]   reg_tgt_i,
    input  logic [W-1:0]   link_i,
    output logic [W-1:0]   target_o,
    output logic           saves_link_o,
    output logic           kind_ok_o
);
    always_comb begin
        target_o     = label_i;
        saves_link_o = 1'b0;
        kind_ok_o    = 1'b1;
        unique case (kind_i)
            KIND_LABEL:      target_o = label_i;
            KIND_LABEL_LINK: begin
                target_o     = label_i;
                saves_link_o = 1'b1;
            end
            KIND_REG:        target_o = reg_tgt_i;
            KIND_REG_LINK: begin
                target_o     = reg_tgt_i;
                saves_link_o = 1'b1;
            end
            KIND_RETURN:     target_o = link_i;
            default:         kind_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   cond_sel_i,
    input  logic [2:0]   kind_i,
    input  logic         flag_c_i,
    input  logic         flag_z_i,
    input  logic         flag_s_i,
    input  logic         flag_v_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] label_i,
    input  logic [W-1:0] reg_tgt_i,
    input  logic [W-1:0] link_i,
    output logic         taken_o,
    output logic [W-1:0] next_pc_o,
    output logic         link_we_o,
    output logic [W-1:0] link_val_o
);
    typedef struct packed {
        logic         taken;
        logic [W-1:0] next_pc;
        logic         link_we;
        logic [W-1:0] link_val;
    } resolve_t;

    localparam resolve_t RESOLVE_IDLE = '0;

    logic         cond_hit;
    logic [W-1:0] target;
    logic         saves_link;
    logic         kind_ok;
    resolve_t     res_d;
    resolve_t     res_q;

    branch_cond_eval u_cond (
        .sel_i (cond_sel_e'(cond_sel_i)),
        .c_i   (flag_c_i),
        .z_i   (flag_z_i),
        .s_i   (flag_s_i),
        .v_i   (flag_v_i),
        .hit_o (cond_hit)
    );

    branch_target_sel #(.W(W)) u_tgt (
        .kind_i       (jump_kind_e'(kind_i)),
        .label_i      (label_i),
        .reg_tgt_i    (reg_tgt_i),
        .link_i       (link_i),
        .target_o     (target),
        .saves_link_o (saves_link),
        .kind_ok_o    (kind_ok)
    );

    always_comb begin
        res_d          = RESOLVE_IDLE;
        res_d.taken    = cond_hit & kind_ok;
        res_d.next_pc  = res_d.taken ? target : pc_i;
        res_d.link_we  = res_d.taken & saves_link;
        res_d.link_val = res_d.link_we ? pc_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= RESOLVE_IDLE;
        else     res_q <= res_d;
    end

    assign taken_o    = res_q.taken;
    assign next_pc_o  = res_q.next_pc;
    assign link_we_o  = res_q.link_we;
    assign link_val_o = res_q.link_val;

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   cond_sel_i,
    input logic [2:0]   kind_i,
    input logic         flag_c_i,
    input logic [W-1:0] pc_i,
    input logic [W-1:0] link_i,
    input logic         taken_o,
    input logic [W-1:0] next_pc_o,
    input logic         link_we_o,
    input logic [W-1:0] link_val_o
);
    // High once the outputs carry a result computed from non-reset inputs.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= !rst;

    assert_no_link_without_jump_R10: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> !link_we_o);

    assert_link_holds_pc_R9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && link_we_o) |-> (link_val_o == $past(pc_i)));

    assert_fallthrough_pc_R10: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !taken_o) |-> (next_pc_o == $past(pc_i)));

    assert_never_code_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(cond_sel_i) == 4'd15) |-> !taken_o);

    assert_bad_kind_R11: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(kind_i) > 3'd4) |-> !taken_o);

    assert_borrow_lower_R4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(cond_sel_i) == 4'd7 && $past(kind_i) == 3'd0)
            |-> (taken_o == $past(flag_c_i)));

    assert_return_target_R8: assert property (@(posedge clk) disable iff (rst)
        (armed_q && taken_o && $past(kind_i) == 3'd4) |-> (next_pc_o == $past(link_i)));

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (!taken_o && !link_we_o && next_pc_o == '0));

endmodule

bind branch_resolve branch_resolve_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cond_sel_i (cond_sel_i),
    .kind_i     (kind_i),
    .flag_c_i   (flag_c_i),
    .pc_i       (pc_i),
    .link_i     (link_i),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   cond_sel_i = '0;
    logic [2:0]   kind_i = '0;
    logic         flag_c_i = 1'b0;
    logic         flag_z_i = 1'b0;
    logic         flag_s_i = 1'b0;
    logic         flag_v_i = 1'b0;
    logic [W-1:0] pc_i = '0;
    logic [W-1:0] label_i = '0;
    logic [W-1:0] reg_tgt_i = '0;
    logic [W-1:0] link_i = '0;
    logic         taken_o;
    logic [W-1:0] next_pc_o;
    logic         link_we_o;
    logic [W-1:0] link_val_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    branch_resolve #(.W(W)) uut (
        .clk(clk), .rst(rst), .cond_sel_i(cond_sel_i), .kind_i(kind_i),
        .flag_c_i(flag_c_i), .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_v_i(flag_v_i),
        .pc_i(pc_i), .label_i(label_i), .reg_tgt_i(reg_tgt_i), .link_i(link_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_val_o(link_val_o)
    );

    // Reference condition table, written from the requirements.
    function automatic bit ref_cond(int code, bit c, bit z, bit s, bit v);
        case (code)
            0:  return 1'b1;
            1:  return v;
            2:  return !v;
            3:  return s;
            4:  return !s;
            5:  return z;
            6:  return !z;
            7:  return c;
            8:  return !c;
            9:  return !(z || (s != v));
            10: return z || (s != v);
            11: return s != v;
            12: return s == v;
            13: return !(c || z);
            14: return c || z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_val(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one decision at a falling edge and judge it at the next falling edge.
    task automatic step(string req, int code, int kind, bit [3:0] cszv,
                        logic [W-1:0] pc, logic [W-1:0] lab, logic [W-1:0] rt, logic [W-1:0] lk);
        bit hit;
        bit tk;
        bit lwe;
        logic [W-1:0] npc;
        cond_sel_i = code[3:0];
        kind_i     = kind[2:0];
        flag_c_i   = cszv[3];
        flag_s_i   = cszv[2];
        flag_z_i   = cszv[1];
        flag_v_i   = cszv[0];
        pc_i = pc; label_i = lab; reg_tgt_i = rt; link_i = lk;
        hit = ref_cond(code, cszv[3], cszv[1], cszv[2], cszv[0]);
        tk  = hit && (kind <= 4);
        lwe = tk && (kind == 1 || kind == 3);
        if (!tk)                   npc = pc;
        else if (kind <= 1)        npc = lab;
        else if (kind <= 3)        npc = rt;
        else                       npc = lk;
        @(negedge clk);
        check_val(req, "taken",    {31'b0, taken_o},   {31'b0, tk});
        check_val(req, "next_pc",  next_pc_o,          npc);
        check_val(req, "link_we",  {31'b0, link_we_o}, {31'b0, lwe});
        check_val(req, "link_val", link_val_o,         lwe ? pc : '0);
    endtask

    task automatic test_reset_R1();
        rst = 1'b1;
        cond_sel_i = 4'd0; kind_i = 3'd1; pc_i = 32'h1111_0000; label_i = 32'h2222_0000;
        @(negedge clk);
        @(negedge clk);
        check_val("R1", "taken",    {31'b0, taken_o},   '0);
        check_val("R1", "next_pc",  next_pc_o,          '0);
        check_val("R1", "link_we",  {31'b0, link_we_o}, '0);
        check_val("R1", "link_val", link_val_o,         '0);
        rst = 1'b0;
    endtask

    task automatic test_latency_R2();
        step("R2", 0, 0, 4'b0000, 32'h100, 32'hA00, 32'hB00, 32'hC00);
        cond_sel_i = 4'd15; pc_i = 32'h104;
        #1;
        check_val("R2", "next_pc held", next_pc_o, 32'hA00);
        @(negedge clk);
        check_val("R2", "next_pc after edge", next_pc_o, 32'h104);
    endtask

    task automatic sweep(string req, int lo, int hi, int kind);
        for (int code = lo; code <= hi; code++)
            for (int f = 0; f < 16; f++)
                step(req, code, kind, f[3:0], 32'h4000 + f, 32'h8000 + code, 32'h9000, 32'hA000);
    endtask

    task automatic test_flags_R3();    sweep("R3", 1, 6, 0);   endtask
    task automatic test_borrow_R4();   sweep("R4", 7, 8, 0);   endtask
    task automatic test_signed_R5();   sweep("R5", 9, 12, 2);  endtask
    task automatic test_unsigned_R6(); sweep("R6", 13, 14, 4); endtask

    task automatic test_always_never_R7();
        for (int f = 0; f < 16; f++) begin
            step("R7", 0, 0, f[3:0], 32'h10, 32'h20, 32'h30, 32'h40);
            step("R7", 15, 0, f[3:0], 32'h10, 32'h20, 32'h30, 32'h40);
        end
    endtask

    task automatic test_targets_R8();
        for (int k = 0; k <= 4; k++)
            step("R8", 0, k, 4'b0000, 32'hCAFE_0000, 32'h0000_1234, 32'h0000_5678, 32'h0000_9ABC);
    endtask

    task automatic test_link_R9();
        step("R9", 0, 1, 4'b0000, 32'h0000_0F00, 32'h0000_2000, 32'h0, 32'h0);
        step("R9", 0, 3, 4'b0000, 32'h0000_0F04, 32'h0, 32'h0000_3000, 32'h0);
        step("R9", 0, 4, 4'b0000, 32'h0000_0F08, 32'h0, 32'h0, 32'h0000_0F00);
    endtask

    task automatic test_cond_link_R10();
        sweep("R10", 1, 14, 1);
        sweep("R10", 1, 14, 3);
    endtask

    task automatic test_bad_kind_R11();
        for (int k = 5; k <= 7; k++) begin
            step("R11", 0, k, 4'b1111, 32'h500, 32'h600, 32'h700, 32'h800);
            step("R11", 5, k, 4'b0010, 32'h504, 32'h600, 32'h700, 32'h800);
        end
    endtask

    initial begin
        test_reset_R1();
        test_latency_R2();
        test_flags_R3();
        test_borrow_R4();
        test_signed_R5();
        test_unsigned_R6();
        test_always_never_R7();
        test_targets_R8();
        test_link_R9();
        test_cond_link_R10();
        test_bad_kind_R11();
        test_reset_R1();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule